// File: doc/BRIEF.md
# Justification-Deciding Rate Adaptation FIFO

This block buffers one tributary's data words and decides, once per justification opportunity, how the framer should adjust that tributary's payload rate. There are four possible outcomes: leave the frame normal, send a negative justification (one extra data byte leaves the buffer), send a single positive justification (one byte fewer) or send a double positive justification (two bytes fewer).

The decision has two possible sources, picked by a mode input. In automatic mode the block compares its own fill level against a programmable upper threshold and a programmable lower threshold. In request mode it follows three external request lines, and a fixed priority settles the case where more than one is asserted.

Writes and reads use the same clock and each has its own enable. The block flags overflow when a write arrives while the buffer is full, and underflow when a read arrives while it is empty. It outputs the chosen action and the matching justification control field. That field is sent three times over so that a receiver can decode it by majority vote.

Top module: `jcf_rate_adapt`

## Requirements
- R1: `fill_level` equals the number of accepted writes minus accepted reads since reset and stays within 0..DEPTH. `full` is high exactly when the level equals DEPTH, and `empty` is high exactly when the level is 0. A write is accepted when `wr_en` is high and the buffer is not full. A read is accepted when `rd_en` is high and the buffer is not empty.
- R2: Data leaves in the order it was written. `rd_data` always shows the oldest stored word, and an accepted read removes that word.
- R3: When `wr_en` is high while `full` is high, `overflow` is high in that same cycle. The write is dropped, and the level and the stored words do not change.
- R4: When `rd_en` is high while `empty` is high, `underflow` is high in that same cycle. The read is ignored and the level stays 0.
- R5: In automatic mode (`req_mode`=0), a strobe that sees a level above `thr_upper` selects negative justification. This test has priority over the positive tests.
- R6: In automatic mode, when the level is not above `thr_upper`, the choice depends on two limits. A level below floor(`thr_lower`/2) selects double positive. Otherwise, a level below `thr_lower` selects single positive. Any other level selects no justification.
- R7: In request mode (`req_mode`=1), `req_neg` selects negative justification. Otherwise `req_dpos` selects double positive. Otherwise `req_pos` selects single positive. With no request line asserted, the choice is none.
- R8: The decision is taken at a clock edge where `opp_strobe` is high. It uses the fill level and the inputs present before that edge, appears on the outputs after that edge, and is held until the next strobe. After reset the action is none.
- R9: `act` uses the encoding none=0, negative=1, single positive=2, double positive=3. The control code is none=00, negative=01, single positive=11, double positive=10. `jc_bits[5:4]`, `jc_bits[3:2]` and `jc_bits[1:0]` each carry that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by writes, reads and decisions |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Oldest stored word |
| thr_upper | input | LVL_W | Level above which automatic mode chooses negative |
| thr_lower | input | LVL_W | Level below which automatic mode chooses positive |
| req_mode | input | 1 | 0 = automatic thresholds, 1 = follow request lines |
| req_neg | input | 1 | Negative justification request |
| req_pos | input | 1 | Single positive justification request |
| req_dpos | input | 1 | Double positive justification request |
| opp_strobe | input | 1 | Justification opportunity; decision is taken at this edge |
| fill_level | output | LVL_W | Current number of stored words |
| full | output | 1 | Level equals DEPTH |
| empty | output | 1 | Level equals 0 |
| overflow | output | 1 | Write attempted while full |
| underflow | output | 1 | Read attempted while empty |
| act | output | 2 | Chosen action |
| jc_bits | output | 6 | Control code, three copies |

## Verification
A level counter that drifts from the real pointer distance shows up on `fill_level` in the next cycle. Because the thresholds are applied to that level, the same fault also gives a wrong action at the next strobe. A bad pointer step shows up as a wrong `rd_data` after at most DEPTH reads. A fault in threshold comparison or request priority appears on `act` and `jc_bits` one cycle after the strobe, and because the decision is held, the wrong value then stays visible until the following strobe. The bench keeps its own queue and decision model, and it compares every output once in every cycle.

// File: rtl/jcf_pkg.sv
package jcf_pkg;

  typedef enum logic [1:0] {
    JA_NONE = 2'd0,
    JA_NEG  = 2'd1,
    JA_POS  = 2'd2,
    JA_DPOS = 2'd3
  } jact_e;

  // Two-bit justification control code for one action.
  function automatic logic [1:0] jc_code(input jact_e a);
    case (a)
      JA_NEG:  jc_code = 2'b01;
      JA_POS:  jc_code = 2'b11;
      JA_DPOS: jc_code = 2'b10;
      default: jc_code = 2'b00;
    endcase
  endfunction

  // Threshold decision; the negative test comes first.
  function automatic jact_e auto_pick(input logic [15:0] lvl,
                                      input logic [15:0] up,
                                      input logic [15:0] lo);
    if (lvl > up)             auto_pick = JA_NEG;
    else if (lvl < (lo >> 1)) auto_pick = JA_DPOS;
    else if (lvl < lo)        auto_pick = JA_POS;
    else                      auto_pick = JA_NONE;
  endfunction

  // Request decision: negative > double positive > single positive.
  function automatic jact_e req_pick(input logic n, input logic d,
                                     input logic p);
    if (n)      req_pick = JA_NEG;
    else if (d) req_pick = JA_DPOS;
    else if (p) req_pick = JA_POS;
    else        req_pick = JA_NONE;
  endfunction

endpackage

// File: rtl/jcf_store.sv
module jcf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic              overflow,
  output logic              underflow
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              wr_ok, rd_ok;

  assign full      = (level == LVL_W'(DEPTH));
  assign empty     = (level == '0);
  assign wr_ok     = wr_en && !full;
  assign rd_ok     = rd_en && !empty;
  assign overflow  = wr_en && full;
  assign underflow = rd_en && empty;
  assign rd_data   = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    ptr_next = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= ptr_next(wr_ptr);
      if (rd_ok) rd_ptr <= ptr_next(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)); // R1
  AST_OVF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !rd_en |=> $stable(level) && full); // R3
  AST_UDF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !wr_en |=> empty); // R4

endmodule

// File: rtl/jcf_decide.sv
module jcf_decide
  import jcf_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thr_upper,
  input  logic [LVL_W-1:0] thr_lower,
  input  logic             req_mode,
  input  logic             req_neg,
  input  logic             req_pos,
  input  logic             req_dpos,
  input  logic             opp_strobe,
  output jact_e            act
);

  jact_e auto_act, req_act, next_act;

  assign auto_act = auto_pick(16'(level), 16'(thr_upper), 16'(thr_lower));
  assign req_act  = req_pick(req_neg, req_dpos, req_pos);
  assign next_act = req_mode ? req_act : auto_act;

  always_ff @(posedge clk) begin
    if (!rst_n)          act <= JA_NONE;
    else if (opp_strobe) act <= next_act;
  end

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !opp_strobe |=> $stable(act)); // R8
  AST_AUTO_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    opp_strobe && !req_mode && (level > thr_upper) |=> act == JA_NEG); // R5
  AST_REQ_NEG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    opp_strobe && req_mode && req_neg |=> act == JA_NEG); // R7
  AST_AUTO_FULL_OK: assert property (@(posedge clk) disable iff (!rst_n)
    opp_strobe && !req_mode && (level >= thr_lower) && (level <= thr_upper)
    |=> act == JA_NONE); // R6

endmodule

// File: rtl/jcf_encode.sv
module jcf_encode
  import jcf_pkg::*;
#(
  parameter int COPIES = 3,
  localparam int JC_W  = 2 * COPIES
) (
  input  jact_e            act,
  output logic [JC_W-1:0]  jc_bits
);

  logic [1:0] code;
  assign code = jc_code(act);

  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    assign jc_bits[2*i +: 2] = code;
  end

  always_comb begin
    AST_COPIES_AGREE: assert (jc_bits[JC_W-1 -: 2] == jc_bits[1:0]); // R9
  end

endmodule

// File: rtl/jcf_rate_adapt.sv
module jcf_rate_adapt
  import jcf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [LVL_W-1:0]  thr_upper,
  input  logic [LVL_W-1:0]  thr_lower,
  input  logic              req_mode,
  input  logic              req_neg,
  input  logic              req_pos,
  input  logic              req_dpos,
  input  logic              opp_strobe,
  output logic [LVL_W-1:0]  fill_level,
  output logic              full,
  output logic              empty,
  output logic              overflow,
  output logic              underflow,
  output logic [1:0]        act,
  output logic [5:0]        jc_bits
);

  jact_e act_q;

  jcf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .level     (fill_level),
    .full      (full),
    .empty     (empty),
    .overflow  (overflow),
    .underflow (underflow)
  );

  jcf_decide #(.LVL_W(LVL_W)) u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .level      (fill_level),
    .thr_upper  (thr_upper),
    .thr_lower  (thr_lower),
    .req_mode   (req_mode),
    .req_neg    (req_neg),
    .req_pos    (req_pos),
    .req_dpos   (req_dpos),
    .opp_strobe (opp_strobe),
    .act        (act_q)
  );

  jcf_encode #(.COPIES(3)) u_encode (
    .act     (act_q),
    .jc_bits (jc_bits)
  );

  assign act = act_q;

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R1

endmodule

// File: tb/test_jcf_rate_adapt.sv
module test_jcf_rate_adapt;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int DEP = 16;
  localparam int LW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, req_mode = 0, req_neg = 0, req_pos = 0;
  logic req_dpos = 0, opp_strobe = 0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [LW-1:0] thr_upper = 5'd12, thr_lower = 5'd4, fill_level;
  logic full, empty, overflow, underflow;
  logic [1:0] act;
  logic [5:0] jc_bits;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] q[$];
  int exp_act = 0;

  jcf_rate_adapt #(.DATA_W(DW), .DEPTH(DEP)) i_jcf_rate_adapt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .thr_upper(thr_upper),
    .thr_lower(thr_lower), .req_mode(req_mode), .req_neg(req_neg),
    .req_pos(req_pos), .req_dpos(req_dpos), .opp_strobe(opp_strobe),
    .fill_level(fill_level), .full(full), .empty(empty),
    .overflow(overflow), .underflow(underflow), .act(act), .jc_bits(jc_bits)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int want_auto(int lvl, int up, int lo);
    if (lvl > up) return 1;
    if (2 * lvl < lo - (lo % 2)) return 3;
    if (lvl < lo) return 2;
    return 0;
  endfunction

  function automatic int want_req(bit n, bit d, bit p);
    return n ? 1 : d ? 3 : p ? 2 : 0;
  endfunction

  function automatic int code_of(int a);
    case (a)
      1: return 1;
      2: return 3;
      3: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int actual,
                     input int expect_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual,
               expect_v, $time);
    end
  endtask

  task automatic chk_state();
    int c;
    c = code_of(exp_act);
    chk(fill_level == LW'(q.size()), "R1 level", fill_level, q.size());
    chk(full == (q.size() == DEP), "R1 full", full, q.size() == DEP);
    chk(empty == (q.size() == 0), "R1 empty", empty, q.size() == 0);
    if (q.size() > 0) chk(rd_data == q[0], "R2 data", rd_data, q[0]);
    chk(act == 2'(exp_act), "R8 act", act, exp_act);
    chk(jc_bits == {2'(c), 2'(c), 2'(c)}, "R9 jc", jc_bits, c * 21);
  endtask

  // Apply one cycle of stimulus (called just after a falling edge).
  task automatic step(input bit w, input bit r, input bit s, input bit m,
                      input bit n, input bit d, input bit p);
    int sz;
    bit wok, rok;
    wr_en = w; rd_en = r; opp_strobe = s; req_mode = m;
    req_neg = n; req_dpos = d; req_pos = p;
    wr_data = DW'($urandom);
    #1;
    sz = q.size();
    chk(overflow == (w && sz == DEP), "R3 overflow", overflow, w && sz == DEP);
    chk(underflow == (r && sz == 0), "R4 underflow", underflow, r && sz == 0);
    wok = w && sz < DEP;
    rok = r && sz > 0;
    if (s) exp_act = m ? want_req(n, d, p)
                       : want_auto(sz, int'(thr_upper), int'(thr_lower));
    if (rok) void'(q.pop_front());
    if (wok) q.push_back(wr_data);
    @(negedge clk);
    chk_state();
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pw;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    chk_state();  // R8 reset action none, R1 empty after reset
    rst_n = 1'b1;

    // Directed: fill past full (R3), then drain past empty (R4).
    thr_upper = 5'd12; thr_lower = 5'd6;
    for (int i = 0; i < DEP + 3; i++) step(1, 0, i == DEP + 1, 0, 0, 0, 0);
    chk(act == 2'd1, "R5 full level gives negative", act, 1);
    step(1, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < DEP + 3; i++) step(0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    chk(act == 2'd3, "R6 empty level gives double positive", act, 3);
    // Boundaries: level 3 = lower/2 -> single; level 6 = lower -> none.
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    chk(act == 2'd2, "R6 half boundary single positive", act, 2);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    chk(act == 2'd0, "R6 at lower threshold none", act, 0);
    // Request priority R7.
    step(0, 0, 1, 1, 1, 1, 1);
    chk(act == 2'd1, "R7 all requests negative", act, 1);
    step(0, 0, 1, 1, 0, 1, 1);
    chk(act == 2'd3, "R7 dpos over pos", act, 3);
    step(0, 0, 0, 1, 1, 0, 0);
    chk(act == 2'd3, "R8 held without strobe", act, 3);

    // Constrained random phases.
    for (int ph = 0; ph < 30; ph++) begin
      pw = (ph % 5 == 0) ? 85 : (ph % 5 == 1) ? 15 : (ph % 5 == 2) ? 50 :
           (ph % 5 == 3) ? 97 : 3;
      thr_upper = LW'(6 + $urandom % 11);
      thr_lower = LW'($urandom % 10);
      for (int i = 0; i < 200; i++)
        step(($urandom % 100) < pw, ($urandom % 100) < (100 - pw),
             ($urandom % 4) == 0, (ph % 3) == 2,
             ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule